// File: doc/BRIEF.md
# Keyed Write Gate for Watchdog Control Bits

This block stands between a CPU write bus and a small control register whose critical bits (watchdog restart, watchdog reset enable and watchdog timeout flag) must not change because of a stray store. Software unlocks those bits by writing two key bytes to a dedicated key address: first 0xAA, then 0x55. This opens a window a few clocks long. During that window exactly one write to the control register may change the guarded bits.

The gate does not hold the control register. It produces a per-bit write enable for it and a status output showing whether the window is open. Bits outside the guard mask stay writable at all times. Any bus write that breaks the sequence, and any wait that runs past the allowed number of clocks, returns the gate to its locked idle state.

Top module: `keyed_write_gate`

## Requirements
- R1: While and right after reset the gate is idle and locked: `win_open` is 0, and no bit whose `PROT_MASK` bit is 1 gets a write enable.
- R2: A write of 0xAA to `KEY_ADDR`, followed by a write of 0x55 to `KEY_ADDR` within 3 clocks, opens the window. If 0x55 arrives in cycle u, `win_open` is 1 in cycles u+1 to u+3.
- R3: If 0x55 arrives 4 or more clocks after the 0xAA write, the window does not open.
- R4: Any other value written to `KEY_ADDR` while waiting for 0x55 (a repeated 0xAA included) returns the gate to idle. A 0x55 with no 0xAA before it does nothing.
- R5: A control-register write (`bus_wr`=1, `bus_addr`=`CTRL_ADDR`) while `win_open` is 1 enables all bits of `ctrl_we` in that same cycle. `win_open` is 0 in the next cycle, so a second write reaches only the unguarded bits.
- R6: If no write arrives, the window closes by itself after 3 clocks. A control write in the fourth cycle after the 0x55 write is locked.
- R7: A control write while the window is closed sets `ctrl_we` to `~PROT_MASK`. With the default mask 0x0B, this is 0xF4, so bits 0, 1 and 3 are locked.
- R8: Any write between the 0xAA and 0x55 keys that is not the 0x55 key write aborts the sequence. This includes a write to another address and a control-register write.
- R9: A key-address write while the window is open closes the window without a grant.
- R10: Cycles with `bus_wr`=0 change no state and enable no bits, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Write address |
| bus_wdata | input | DATA_W | Write data |
| ctrl_we | output | DATA_W | Per-bit write enable for the control register |
| win_open | output | 1 | High while a guarded write would be accepted |

## Verification
The bench goes after the edges of both timing windows. It sends 0x55 exactly 3 clocks and then 4 clocks after 0xAA, and it sends the control write in the last open cycle and then in the first closed one. A counter that is off by one would open the window late, keep it open a cycle too long, or refuse a key sequence that should work. The bench also checks three interruptions of the sequence: a repeated 0xAA, a foreign-address write, and a back-to-back second control write. A gate that let these through would grant a guarded write to code that had not run the exact key sequence, or would grant two guarded writes for one unlock. Idle bus cycles with key-like address and data check that a gate which reacts to address alone is caught.

// File: rtl/keyed_write_gate.sv
module keyed_write_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter logic [DATA_W-1:0] PROT_MASK  = 8'h0B,
  parameter int GAP_CYC  = 3,
  parameter int OPEN_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] ctrl_we,
  output logic              win_open
);
  localparam int MAX_CYC = (GAP_CYC > OPEN_CYC) ? GAP_CYC : OPEN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] GAP_LIM  = CNT_W'(GAP_CYC);
  localparam logic [CNT_W-1:0] OPEN_LIM = CNT_W'(OPEN_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_OPEN} gate_st_e;

  gate_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  wire key_wr  = bus_wr && (bus_addr == KEY_ADDR);
  wire ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

  assign win_open = (st_q == S_OPEN);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit_we
    if (PROT_MASK[i]) begin : g_guarded
      assign ctrl_we[i] = ctrl_wr && win_open;
    end else begin : g_free
      assign ctrl_we[i] = ctrl_wr;
    end
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE: begin
        if (key_wr && bus_wdata == KEY_FIRST) begin
          st_d  = S_ARMED;
          cnt_d = CNT_ONE;
        end
      end
      S_ARMED: begin
        if (key_wr && bus_wdata == KEY_SECOND) begin
          st_d  = S_OPEN;
          cnt_d = CNT_ONE;
        end else if (bus_wr || cnt_q == GAP_LIM) begin
          st_d = S_IDLE;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      S_OPEN: begin
        if (bus_wr || cnt_q == OPEN_LIM) st_d = S_IDLE;
        else cnt_d = cnt_q + CNT_ONE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

module keyed_write_gate_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC7,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hD8,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter logic [DATA_W-1:0] PROT_MASK  = 8'h0B,
  parameter int OPEN_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] ctrl_we,
  input logic              win_open
);
  int open_run;
  always_ff @(posedge clk) begin
    if (!rst_n) open_run <= 0;
    else if (win_open) open_run <= open_run + 1;
    else open_run <= 0;
  end

  a_r1_locked_in_reset: assert property (@(posedge clk) !rst_n |=> !win_open);

  a_r2_opens_on_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(bus_wr && bus_addr == KEY_ADDR && bus_wdata == KEY_SECOND));

  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == CTRL_ADDR && win_open) |=> !win_open);

  a_r6_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    open_run <= OPEN_CYC);

  a_r7_guard_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> (ctrl_we & PROT_MASK) == '0);

  a_r9_key_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && bus_wr && bus_addr == KEY_ADDR) |=> !win_open);

  a_r10_no_write_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> ctrl_we == '0);
endmodule

bind keyed_write_gate keyed_write_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
  .KEY_SECOND(KEY_SECOND), .PROT_MASK(PROT_MASK), .OPEN_CYC(OPEN_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl_we(ctrl_we), .win_open(win_open)
);

// File: tb/keyed_write_gate_tb_top.sv
module keyed_write_gate_tb_top;
  localparam logic [7:0] KA = 8'hC7, CA = 8'hD8, OA = 8'h10, MASK = 8'h0B;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] ctrl_we;
  logic win_open;
  int n_chk = 0, n_fail = 0;
  int mst = 0, mcnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_write_gate dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_we(ctrl_we), .win_open(win_open)
  );

  function automatic logic [7:0] exp_we(logic w, logic [7:0] a, int st);
    if (!(w && a == CA)) return 8'h00;
    return (st == 2) ? 8'hFF : ~MASK;
  endfunction

  function automatic string pick_tag(logic w, logic [7:0] a, logic [7:0] d, int st);
    if (!w) return "R10";
    if (st == 2) return (a == CA) ? "R5" : (a == KA) ? "R9" : "R8";
    if (st == 1) return (a == KA && d == 8'h55) ? "R2" : (a == KA) ? "R4" : "R8";
    return (a == CA) ? "R7" : "R4";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(logic w, logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    check(tag, {7'd0, win_open}, {7'd0, mst == 2});
    check(tag, ctrl_we, exp_we(w, a, mst));
    case (mst)
      0: if (w && a == KA && d == 8'hAA) begin mst = 1; mcnt = 1; end
      1: if (w && a == KA && d == 8'h55) begin mst = 2; mcnt = 1; end
         else if (w || mcnt == 3) mst = 0;
         else mcnt++;
      default: if (w || mcnt == 3) mst = 0; else mcnt++;
    endcase
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, KA, 8'h55, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic w;
    logic [7:0] a, d;
    int r;
    void'($urandom(32'd20240611));
    // R1: reset state, a control write during reset must stay guarded
    repeat (3) @(negedge clk);
    bus_wr = 1; bus_addr = CA; bus_wdata = 8'hFF;
    #1;
    check("R1", {7'd0, win_open}, 8'h00);
    check("R1", ctrl_we & MASK, 8'h00);
    @(negedge clk); rst_n = 1; bus_wr = 0;
    step(1'b1, CA, 8'h00, "R1");

    step(1'b1, KA, 8'hAA, "R2"); step(1'b1, KA, 8'h55, "R2"); idle(4, "R2");
    step(1'b1, KA, 8'hAA, "R3"); idle(2, "R3"); step(1'b1, KA, 8'h55, "R3");
    step(1'b1, CA, 8'h00, "R3");
    step(1'b1, KA, 8'hAA, "R3"); idle(3, "R3"); step(1'b1, KA, 8'h55, "R3");
    step(1'b1, CA, 8'h00, "R3");
    step(1'b1, KA, 8'hAA, "R4"); step(1'b1, KA, 8'h12, "R4"); step(1'b1, KA, 8'h55, "R4");
    step(1'b1, KA, 8'hAA, "R4"); step(1'b1, KA, 8'hAA, "R4"); step(1'b1, KA, 8'h55, "R4");
    step(1'b1, KA, 8'h55, "R4"); step(1'b1, CA, 8'h00, "R4");
    step(1'b1, KA, 8'hAA, "R5"); step(1'b1, KA, 8'h55, "R5");
    step(1'b1, CA, 8'h0B, "R5"); step(1'b1, CA, 8'h0B, "R5");
    step(1'b1, KA, 8'hAA, "R6"); step(1'b1, KA, 8'h55, "R6"); idle(2, "R6");
    step(1'b1, CA, 8'h01, "R6");
    step(1'b1, KA, 8'hAA, "R6"); step(1'b1, KA, 8'h55, "R6"); idle(3, "R6");
    step(1'b1, CA, 8'h01, "R6");
    step(1'b1, CA, 8'hFF, "R7");
    step(1'b1, KA, 8'hAA, "R8"); step(1'b1, OA, 8'h55, "R8"); step(1'b1, KA, 8'h55, "R8");
    step(1'b1, KA, 8'hAA, "R8"); step(1'b1, CA, 8'h00, "R8"); step(1'b1, KA, 8'h55, "R8");
    step(1'b1, KA, 8'hAA, "R9"); step(1'b1, KA, 8'h55, "R9");
    step(1'b1, KA, 8'hAA, "R9"); step(1'b1, CA, 8'h01, "R9");
    step(1'b1, KA, 8'hAA, "R10"); step(1'b0, CA, 8'h12, "R10"); step(1'b1, KA, 8'h55, "R10");
    step(1'b0, CA, 8'hFF, "R10"); step(1'b1, CA, 8'hFF, "R10");

    for (int i = 0; i < 4000; i++) begin
      r = $urandom_range(0, 99);
      w = (r >= 20);
      a = (r < 55) ? KA : (r < 85) ? CA : 8'($urandom);
      r = $urandom_range(0, 9);
      d = (r < 4) ? 8'hAA : (r < 8) ? 8'h55 : 8'($urandom);
      step(w, a, d, pick_tag(w, a, d, mst));
    end
    finish_run();
  end
endmodule